// File: doc/BRIEF.md
# Sequential Page Read Engine

This block is the device-side read engine of a byte-wide, page-organised read-only store. A command decoder in front of it hands over a start request with a page number, a start column and a flag that selects the spare area. The engine then reports busy on an active-low ready flag for a programmable page-load time. After that it serves one byte for each pulse of the read strobe. Each page is 528 bytes: columns 0 to 511 are main data and columns 512 to 527 are spare bytes, which always read as FFh. The column advances by itself.

At the end of a page the engine keeps going. It waits for a short window and inserts another load period, then resumes on the next page. It stops after the last page of the current 32-page block. Raising the chip enable aborts a read. Raising it inside the window right after the last strobe of a page ends the read with no further busy period. A reset request aborts everything and holds busy for the reset time. The array contents come from a computed function of page and column, which stands in for the ROM cells.

States: `ST_IDLE` (ready, nothing to read), `ST_LOAD` (busy, page load), `ST_READ` (ready, strobes serve bytes), `ST_PEND` (ready, window after the last byte of a page), `ST_RST` (busy, reset). The transitions are as follows:
- An accepted start moves `ST_IDLE`, `ST_READ` or `ST_PEND` to `ST_LOAD`.
- When the load timer expires, `ST_LOAD` moves to `ST_READ`.
- A strobe release at column 527 moves `ST_READ` to `ST_PEND`, or to `ST_IDLE` on the last page of the block.
- When the window expires, `ST_PEND` moves to `ST_LOAD`.
- Chip enable high moves `ST_LOAD`, `ST_READ` or `ST_PEND` to `ST_IDLE`.
- A reset request moves any state to `ST_RST`.
- When the reset timer expires, `ST_RST` moves to `ST_IDLE`.

Top module: `page_read_engine`

## Requirements
- R1: After `rst_ni` is released, `ready_o` is 1, `data_oe_o` is 0 and `proto_err_o` is 0.
- R2: A byte read from any column 512–527 is FFh, in both main and spare mode.
- R3: A start request with `ce_ni` low drives `ready_o` low for exactly `LOAD_CYCLES` clocks, beginning the clock after the request. `ready_o` then returns to 1.
- R4: Each low pulse of `re_ni` in the read state presents the byte at the current column. The column advances by one when `re_ni` returns high. A main byte at column c of page p equals `c[7:0] ^ {p[6:0], c[8]}`.
- R5: Page low five bits not 31: the release of the strobe at column 527 is followed by `CEH_WIN_CYCLES` ready clocks and then `LOAD_CYCLES` busy clocks. Reading then resumes at column 0 of the next page.
- R6: With `spare_mode_i` set, reading starts at column 512 + `start_col_i[3:0]`. On every following page it resumes at column 512.
- R7: Page low five bits equal to 31: after the release of the strobe at column 527, the engine goes idle without any busy period.
- R8: A `reset_req_i` pulse aborts any read and drives `ready_o` low for exactly `RST_CYCLES` clocks.
- R9: If `ce_ni` goes high during the window after the last strobe of a page, no load busy follows and the read ends.
- R10: If `ce_ni` goes high during load or read, the read ends and `ready_o` is 1 on the next clock.
- R11: `data_oe_o` is 1 only while in the read state with `ce_ni` low and `re_ni` low.
- R12: A falling `re_ni` outside the read state produces no data and raises `proto_err_o` for one clock. It does not alter the busy time or the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request from the decoder, one clock |
| spare_mode_i | input | 1 | Read only the spare columns |
| start_col_i | input | 9 | Start column (main) or spare offset in bits 3:0 |
| start_page_i | input | 16 | Page number; low five bits are page within block |
| reset_req_i | input | 1 | Reset request, one clock |
| ce_ni | input | 1 | Chip enable, active low |
| re_ni | input | 1 | Read strobe, active low, synchronous to clk_i |
| data_o | output | 8 | Byte at the current column |
| data_oe_o | output | 1 | Output enable for the data bus |
| ready_o | output | 1 | 1 = ready, 0 = busy |
| proto_err_o | output | 1 | One-clock pulse on a stray strobe |

## Verification
The properties take several things for granted about the inputs:
- A start request comes only while the engine is ready.
- Strobe levels stay low and high for at least one clock each.
- A reset request is a single-clock pulse.

The abort property also relies on the engine leaving any state except reset when chip enable is high. The stimulus issues starts only after `ready_o` has been seen high. It shapes every strobe as one clock low and one clock high. It lowers chip enable again only after its abort effect has been checked, so the sequences stay inside what the properties expect.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READ,
        ST_PEND,
        ST_RST
    } prd_state_e;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/prd_timer.sv
`timescale 1ns/1ps
module prd_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prd_addr_ctr.sv
`timescale 1ns/1ps
module prd_addr_ctr #(
    parameter int unsigned PAGE_COLS     = 528,
    parameter int unsigned MAIN_COLS     = 512,
    parameter int unsigned PAGES_PER_BLK = 32,
    parameter int unsigned PAGE_W        = 16
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                load_i,
    input  logic                                spare_i,
    input  logic [$clog2(MAIN_COLS)-1:0]        start_col_i,
    input  logic [PAGE_W-1:0]                   start_page_i,
    input  logic                                inc_col_i,
    input  logic                                next_page_i,
    output logic [$clog2(PAGE_COLS)-1:0]        col_o,
    output logic [PAGE_W-1:0]                   page_o,
    output logic                                last_col_o,
    output logic                                last_page_o
);
    localparam int unsigned COL_W      = $clog2(PAGE_COLS);
    localparam int unsigned SPARE_COLS = PAGE_COLS - MAIN_COLS;
    localparam int unsigned SP_W       = $clog2(SPARE_COLS);
    localparam int unsigned BLK_BITS   = $clog2(PAGES_PER_BLK);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(PAGE_COLS - 1);
    localparam logic [COL_W-1:0] SPARE_COL = COL_W'(MAIN_COLS);

    logic [COL_W-1:0]  col_q;
    logic [PAGE_W-1:0] page_q;
    logic              spare_q;
    logic [COL_W-1:0]  start_col_w;

    always_comb begin
        if (spare_i) begin
            start_col_w = SPARE_COL + COL_W'(start_col_i[SP_W-1:0]);
        end else begin
            start_col_w = COL_W'(start_col_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            col_q   <= '0;
            page_q  <= '0;
            spare_q <= 1'b0;
        end else if (load_i) begin
            col_q   <= start_col_w;
            page_q  <= start_page_i;
            spare_q <= spare_i;
        end else if (next_page_i) begin
            col_q                 <= spare_q ? SPARE_COL : '0;
            page_q[BLK_BITS-1:0]  <= page_q[BLK_BITS-1:0] + 1'b1;
        end else if (inc_col_i) begin
            col_q <= col_q + 1'b1;
        end
    end

    assign col_o       = col_q;
    assign page_o      = page_q;
    assign last_col_o  = (col_q == LAST_COL);
    assign last_page_o = &page_q[BLK_BITS-1:0];
endmodule

// File: rtl/prd_rom_model.sv
`timescale 1ns/1ps
module prd_rom_model
    import prd_pkg::*;
#(
    parameter int unsigned PAGE_COLS = 528,
    parameter int unsigned MAIN_COLS = 512
) (
    input  logic [6:0]                   page_lo_i,
    input  logic [$clog2(PAGE_COLS)-1:0] col_i,
    output byte_t                        data_o
);
    localparam int unsigned COL_W = $clog2(PAGE_COLS);

    always_comb begin
        if (col_i >= COL_W'(MAIN_COLS)) begin
            data_o = 8'hFF;
        end else begin
            data_o = col_i[7:0] ^ {page_lo_i, col_i[8]};
        end
    end
endmodule

// File: rtl/page_read_engine.sv
`timescale 1ns/1ps
module page_read_engine
    import prd_pkg::*;
#(
    parameter int unsigned PAGE_COLS      = 528,
    parameter int unsigned MAIN_COLS      = 512,
    parameter int unsigned PAGES_PER_BLK  = 32,
    parameter int unsigned PAGE_W         = 16,
    parameter int unsigned LOAD_CYCLES    = 1400,
    parameter int unsigned RST_CYCLES     = 1200,
    parameter int unsigned CEH_WIN_CYCLES = 20
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic                         spare_mode_i,
    input  logic [$clog2(MAIN_COLS)-1:0] start_col_i,
    input  logic [PAGE_W-1:0]            start_page_i,
    input  logic                         reset_req_i,
    input  logic                         ce_ni,
    input  logic                         re_ni,
    output logic [7:0]                   data_o,
    output logic                         data_oe_o,
    output logic                         ready_o,
    output logic                         proto_err_o
);
    localparam int unsigned COL_W    = $clog2(PAGE_COLS);
    localparam int unsigned LAST_COL = PAGE_COLS - 1;
    localparam int unsigned T_AB     = (LOAD_CYCLES > RST_CYCLES) ? LOAD_CYCLES : RST_CYCLES;
    localparam int unsigned T_MAX    = (T_AB > CEH_WIN_CYCLES) ? T_AB : CEH_WIN_CYCLES;
    localparam int unsigned CNT_W    = $clog2(T_MAX + 1);

    prd_state_e       state_q, state_d;
    logic             re_q;
    logic             re_fall, re_rise;
    logic             go_start;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             ctr_load, ctr_inc, ctr_next;
    logic [COL_W-1:0] col;
    logic [PAGE_W-1:0] page;
    logic             last_col, last_page;
    logic             err_q;
    byte_t            rom_byte;

    assign re_fall  = re_q & ~re_ni;
    assign re_rise  = ~re_q & re_ni;
    assign go_start = start_i & ~ce_ni &
                      ((state_q == ST_IDLE) || (state_q == ST_READ) || (state_q == ST_PEND));

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (reset_req_i) begin
            state_d = ST_RST;
        end else if (go_start) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_LOAD: begin
                    if (ce_ni)         state_d = ST_IDLE;
                    else if (tmr_zero) state_d = ST_READ;
                end
                ST_READ: begin
                    if (ce_ni) begin
                        state_d = ST_IDLE;
                    end else if (re_rise && last_col) begin
                        state_d = last_page ? ST_IDLE : ST_PEND;
                    end
                end
                ST_PEND: begin
                    if (ce_ni)         state_d = ST_IDLE;
                    else if (tmr_zero) state_d = ST_LOAD;
                end
                ST_RST: begin
                    if (tmr_zero) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            re_q    <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            re_q    <= re_ni;
            err_q   <= re_fall && (state_q != ST_READ);
        end
    end

    // timer and address control
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (reset_req_i) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RST_CYCLES - 1);
        end else if ((state_d != state_q) || go_start) begin
            if (state_d == ST_LOAD) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LOAD_CYCLES - 1);
            end else if (state_d == ST_PEND) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(CEH_WIN_CYCLES - 1);
            end
        end
        ctr_load = go_start && !reset_req_i;
        ctr_next = (state_q == ST_PEND) && (state_d == ST_LOAD) && !go_start;
        ctr_inc  = (state_q == ST_READ) && (state_d == ST_READ) && re_rise && !last_col;
    end

    // outputs
    always_comb begin
        ready_o     = !((state_q == ST_LOAD) || (state_q == ST_RST));
        data_oe_o   = (state_q == ST_READ) && !ce_ni && !re_ni;
        data_o      = rom_byte;
        proto_err_o = err_q;
    end

    prd_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    prd_addr_ctr #(
        .PAGE_COLS     (PAGE_COLS),
        .MAIN_COLS     (MAIN_COLS),
        .PAGES_PER_BLK (PAGES_PER_BLK),
        .PAGE_W        (PAGE_W)
    ) u_addr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_i       (ctr_load),
        .spare_i      (spare_mode_i),
        .start_col_i  (start_col_i),
        .start_page_i (start_page_i),
        .inc_col_i    (ctr_inc),
        .next_page_i  (ctr_next),
        .col_o        (col),
        .page_o       (page),
        .last_col_o   (last_col),
        .last_page_o  (last_page)
    );

    prd_rom_model #(
        .PAGE_COLS (PAGE_COLS),
        .MAIN_COLS (MAIN_COLS)
    ) u_rom (
        .page_lo_i (page[6:0]),
        .col_i     (col),
        .data_o    (rom_byte)
    );
endmodule

// File: rtl/page_read_engine_chk.sv
`timescale 1ns/1ps
module page_read_engine_chk
    import prd_pkg::*;
#(
    parameter int unsigned COL_W     = 10,
    parameter int unsigned MAIN_COLS = 512,
    parameter int unsigned LAST_COL  = 527
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ce_ni,
    input logic             re_ni,
    input logic             reset_req_i,
    input logic [7:0]       data_o,
    input logic             data_oe_o,
    input logic             ready_o,
    input logic             proto_err_o,
    input prd_state_e       state_q,
    input logic [COL_W-1:0] col
);
    p_oe_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_oe_o |-> (ready_o && !ce_ni && !re_ni));

    p_spare_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_oe_o && (col >= COL_W'(MAIN_COLS))) |-> (data_o == 8'hFF));

    p_reset_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_req_i |=> !ready_o);

    p_ce_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_ni && !reset_req_i && (state_q != ST_RST)) |=> ready_o);

    p_err_outside_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        proto_err_o |-> $past(state_q != ST_READ));

    p_col_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        col <= COL_W'(LAST_COL));
endmodule

bind page_read_engine page_read_engine_chk #(
    .COL_W     (COL_W),
    .MAIN_COLS (MAIN_COLS),
    .LAST_COL  (LAST_COL)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .re_ni       (re_ni),
    .reset_req_i (reset_req_i),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .ready_o     (ready_o),
    .proto_err_o (proto_err_o),
    .state_q     (state_q),
    .col         (col)
);

// File: tb/page_read_engine_tb_top.sv
`timescale 1ns/1ps
module page_read_engine_tb_top;
    localparam int LOAD_N = 8;
    localparam int RST_N  = 6;
    localparam int WIN_N  = 3;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        spare_mode_i = 1'b0;
    logic [8:0]  start_col_i = '0;
    logic [15:0] start_page_i = '0;
    logic        reset_req_i = 1'b0;
    logic        ce_ni = 1'b1;
    logic        re_ni = 1'b1;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        ready_o;
    logic        proto_err_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    exp_t exp_q[$];
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    page_read_engine #(
        .LOAD_CYCLES    (LOAD_N),
        .RST_CYCLES     (RST_N),
        .CEH_WIN_CYCLES (WIN_N)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .spare_mode_i (spare_mode_i),
        .start_col_i  (start_col_i),
        .start_page_i (start_page_i),
        .reset_req_i  (reset_req_i),
        .ce_ni        (ce_ni),
        .re_ni        (re_ni),
        .data_o       (data_o),
        .data_oe_o    (data_oe_o),
        .ready_o      (ready_o),
        .proto_err_o  (proto_err_o)
    );

    function automatic logic [7:0] main_byte(int page, int col);
        logic [15:0] p;
        logic [9:0]  c;
        p = 16'(page);
        c = 10'(col);
        return c[7:0] ^ {p[6:0], c[8]};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: compares each served byte with the scoreboard
    always @(negedge clk) begin
        #1;
        if (data_oe_o && !oe_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected output", int'(data_o), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(data_o == e.val, e.tag, int'(data_o), int'(e.val));
            end
        end
        oe_prev = data_oe_o;
    end

    task automatic start_rd(bit sp, int col, int page);
        @(negedge clk);
        start_i      = 1'b1;
        spare_mode_i = sp;
        start_col_i  = 9'(col);
        start_page_i = 16'(page);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic busy_len(int exp, string tag);
        int n = 0;
        while (!ready_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic re_pulse(logic [7:0] val, string tag);
        exp_t e;
        e.val = val;
        e.tag = tag;
        re_ni = 1'b0;
        exp_q.push_back(e);
        @(negedge clk);
        re_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic re_stray(string tag);
        re_ni = 1'b0;
        @(negedge clk);
        chk(proto_err_o == 1'b1, tag, int'(proto_err_o), 1);
        chk(data_oe_o == 1'b0, tag, int'(data_oe_o), 0);
        re_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic stays_ready(int cycles, string tag);
        int low = 0;
        for (int i = 0; i < cycles; i++) begin
            if (!ready_o) low++;
            @(negedge clk);
        end
        chk(low == 0, tag, low, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
        chk(data_oe_o == 1'b0, "R1 oe", int'(data_oe_o), 0);
        chk(proto_err_o == 1'b0, "R1 err", int'(proto_err_o), 0);
        ce_ni = 1'b0;

        // main read across a page boundary: R3 R4 R2 R5 R11
        start_rd(1'b0, 508, 5);
        busy_len(LOAD_N, "R3 load busy");
        chk(data_oe_o == 1'b0, "R11 oe with strobe high", int'(data_oe_o), 0);
        for (int c = 508; c < 512; c++) re_pulse(main_byte(5, c), "R4 main byte");
        for (int c = 512; c < 528; c++) re_pulse(8'hFF, "R2 spare byte");
        k = 0;
        while (ready_o && k < 50) begin
            k++;
            @(negedge clk);
        end
        chk(k == WIN_N, "R5 window before load", k, WIN_N);
        busy_len(LOAD_N, "R5 page load busy");
        re_pulse(main_byte(6, 0), "R5 next page col 0");
        re_pulse(main_byte(6, 1), "R4 column advance");

        // R10 abort during read
        ce_ni = 1'b1;
        @(negedge clk);
        chk(ready_o == 1'b1, "R10 ready after abort", int'(ready_o), 1);
        ce_ni = 1'b0;
        re_stray("R10 read ended");

        // spare mode: R6 R2, then CE within window: R9
        start_rd(1'b1, 14, 2);
        busy_len(LOAD_N, "R3 load busy spare");
        re_pulse(8'hFF, "R6 spare start col 526");
        re_pulse(8'hFF, "R2 spare col 527");
        k = 0;
        while (ready_o && k < 50) begin
            k++;
            @(negedge clk);
        end
        chk(k == WIN_N, "R6 window", k, WIN_N);
        busy_len(LOAD_N, "R6 load busy");
        for (int c = 512; c < 528; c++) re_pulse(8'hFF, "R6 resume at 512");
        k = 0;
        while (ready_o && k < 50) begin
            k++;
            @(negedge clk);
        end
        chk(k == WIN_N, "R6 sixteen bytes per spare page", k, WIN_N);
        busy_len(LOAD_N, "R6 load busy page 4");
        re_pulse(8'hFF, "R6 page 4 col 512");
        for (int c = 513; c < 528; c++) re_pulse(8'hFF, "R2 spare page 4");
        ce_ni = 1'b1;
        stays_ready(WIN_N + LOAD_N + 4, "R9 no busy after CE in window");
        ce_ni = 1'b0;
        @(negedge clk);
        re_stray("R9 read ended");

        // last page of block: R7
        start_rd(1'b0, 510, 63);
        busy_len(LOAD_N, "R3 load busy last page");
        re_pulse(main_byte(63, 510), "R4 main byte 510");
        re_pulse(main_byte(63, 511), "R4 main byte 511");
        for (int c = 512; c < 528; c++) re_pulse(8'hFF, "R2 spare last page");
        stays_ready(WIN_N + LOAD_N + 4, "R7 stop at block end");
        re_stray("R7 idle after block end");

        // R10 abort during load
        start_rd(1'b0, 0, 1);
        @(negedge clk);
        ce_ni = 1'b1;
        @(negedge clk);
        chk(ready_o == 1'b1, "R10 abort load", int'(ready_o), 1);
        ce_ni = 1'b0;
        @(negedge clk);
        chk(ready_o == 1'b1, "R10 no load resumes", int'(ready_o), 1);

        // R12 strobe during busy
        start_rd(1'b0, 3, 9);
        re_stray("R12 strobe while busy");
        busy_len(LOAD_N - 2, "R12 busy time unchanged");
        re_pulse(main_byte(9, 3), "R12 column unchanged");

        // R8 reset request during read
        reset_req_i = 1'b1;
        @(negedge clk);
        reset_req_i = 1'b0;
        busy_len(RST_N, "R8 reset busy");
        re_stray("R8 read aborted");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected bytes served", exp_q.size(), 0);
        finish_up();
    end
endmodule